// File: doc/BRIEF.md
# LPC Memory Cycle Target

This block sits on the target side of a Low Pin Count bus and serves single-byte memory reads and writes to a byte-wide flash core. It samples the frame strobe and the 4-bit multiplexed LAD bus on every rising clock edge. It accepts a cycle only when the chip enable was low on the clock before the start nibble. It then decodes the cycle type and shifts in a 32-bit address one nibble at a time. Four address bits must equal the inverse of the strapped device ID, so that several targets can share one bus. When the address does not match, the target stays silent for the rest of the cycle.

On a write, the target collects the data byte, waits out the host's turnaround, and drives a ready sync. During that same clock it pulses a one-cycle write request to the core. It then drives turnaround and releases the bus. On a read, the target raises a read request and drives a long-wait sync until the core reports data ready. It then drives a ready sync, returns the byte low nibble first, and turns the bus around. A low frame strobe in any state abandons the current cycle and starts start-nibble detection again.

States, all held in `lpc_tgt_fsm`:
- IDLE moves to TYPE on a claimed start.
- TYPE moves to ADDR, or back to IDLE when the cycle type is not a memory cycle.
- ADDR moves to WLO (write) or HTAR1 (read) when the ID matches, and to IDLE on a mismatch.
- WLO moves to WHI, and WHI moves to HTAR1.
- HTAR1 moves to HTAR2.
- HTAR2 moves to SYNC (write) or RWAIT (read).
- RWAIT stays in RWAIT until the core is ready, then moves to SYNC.
- SYNC moves to TTAR1 (write) or RLO (read).
- RLO moves to RHI, and RHI moves to TTAR1.
- TTAR1 moves to TTAR2, and TTAR2 moves back to IDLE.
- A low frame strobe overrides every transition: it goes to TYPE for a claimed start and to IDLE otherwise.

Top module: `lpc_mem_target`

## Requirements
- R1: While reset is held, `lad_oe`, `core_rd_req` and `core_wr_req` are all 0.
- R2: The target claims a cycle only if two things are true at one rising edge: `frame_n` is 0 with `lad_in` = 0000b, and `chip_en_n` was 0 at the previous edge. Otherwise the cycle gets no bus drive and no request.
- R3: The cycle-type nibble (the clock after start) selects the operation: 010Xb is a memory read and 011Xb is a memory write, with bit 0 ignored. Any other value is ignored, with no bus drive and no request.
- R4: The address is taken over the next 8 clocks, most-significant nibble first (A[31:28] down to A[3:0]). The full address appears on `core_addr` during the request.
- R5: Address bits A[23:20] must equal the bitwise inverse of `strap_id`. On a mismatch the target never drives LAD and issues no request for that cycle.
- R6: A write's data byte is taken in 2 clocks, low nibble first. After the host's 2 turnaround clocks, `core_wr_req` is high for exactly one clock, together with the ready sync, while `core_addr` and `core_wdata` are valid.
- R7: The target waits through the host's 2-clock turnaround. After its own sync (and data on reads) it drives 1111b for one clock, then releases LAD. `lad_oe` is high only during the target's sync, data and first turnaround clocks.
- R8: On a read, `core_rd_req` stays high and LAD shows the wait sync 0110b on every clock until `core_rdy` is sampled high. The next clock shows the ready sync 0000b, followed by `core_rdata` low nibble then high nibble.
- R9: `frame_n` low at any edge abandons the current cycle, and the next clock has `lad_oe` low. A start nibble at that edge begins a fresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Cycle framing strobe, active low |
| lad_in | input | 4 | Multiplexed LAD nibble as seen at the pad |
| lad_out | output | 4 | Nibble the target drives onto LAD |
| lad_oe | output | 1 | Output enable for the LAD pad drivers |
| chip_en_n | input | 1 | Chip enable, active low |
| strap_id | input | 4 | Strapped device ID |
| core_addr | output | 32 | Collected byte address for the core |
| core_wdata | output | 8 | Collected write byte |
| core_wr_req | output | 1 | One-clock write request to the core |
| core_rd_req | output | 1 | Read request, held until the core is ready |
| core_rdata | input | 8 | Read byte from the core |
| core_rdy | input | 1 | Core read data valid |

## Verification
Assertions check the timing invariants on every clock: the write request is a single clock that lines up with a driven ready sync, the read request always comes with a driven wait sync, the bus is released after the target's turnaround, and a low frame strobe releases the bus on the next clock. Other behaviour appears only in whole bus cycles run by the bench. That covers nibble order of address and data, the ID compare against the strap, the chip-enable timing, cycle-type filtering, the exact number of wait-sync clocks, and a cycle abandoned partway through its address.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_TYPE,
        S_ADDR,
        S_WLO,
        S_WHI,
        S_HTAR1,
        S_HTAR2,
        S_RWAIT,
        S_SYNC,
        S_RLO,
        S_RHI,
        S_TTAR1,
        S_TTAR2
    } tgt_state_e;

    localparam logic [NIB_W-1:0] NIB_START     = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_SYNC_OK   = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_SYNC_WAIT = 4'b0110;
    localparam logic [NIB_W-1:0] NIB_TAR       = 4'b1111;
    localparam logic [2:0]       TYPE_MEM_RD   = 3'b010;
    localparam logic [2:0]       TYPE_MEM_WR   = 3'b011;

endpackage

// File: rtl/lpc_tgt_capture.sv
module lpc_tgt_capture
    import lpc_tgt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  lad_in,
    input  logic              addr_shift,
    input  logic [DATA_W/NIB_W-1:0] wnib_take,
    input  logic              rd_take,
    input  logic [DATA_W-1:0] core_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_nxt,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);

    localparam int DNIBS = DATA_W / NIB_W;

    assign addr_nxt = {addr_q[ADDR_W-NIB_W-1:0], lad_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_shift) begin
            addr_q <= addr_nxt;
        end
    end

    // One register per data nibble; bus order is low nibble first.
    for (genvar g = 0; g < DNIBS; g++) begin : g_wnib
        logic [NIB_W-1:0] nib_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                nib_q <= '0;
            end else if (wnib_take[g]) begin
                nib_q <= lad_in;
            end
        end
        assign wdata[g*NIB_W +: NIB_W] = nib_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_take) begin
            rdata_q <= core_rdata;
        end
    end

endmodule

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm
    import lpc_tgt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int ID_W   = 4,
    parameter int ID_LSB = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [NIB_W-1:0]  lad_in,
    input  logic              chip_en_n,
    input  logic [ID_W-1:0]   strap_id,
    input  logic [ADDR_W-1:0] addr_nxt,
    input  logic [DATA_W-1:0] rdata_q,
    input  logic              core_rdy,
    output logic              addr_shift,
    output logic [DATA_W/NIB_W-1:0] wnib_take,
    output logic              rd_take,
    output logic [NIB_W-1:0]  lad_out,
    output logic              lad_oe,
    output logic              core_rd_req,
    output logic              core_wr_req
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int CNT_W     = $clog2(ADDR_NIBS);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);

    tgt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             is_wr_q, is_wr_d;
    logic             ce_q;
    logic             id_ok;

    assign id_ok = (addr_nxt[ID_LSB +: ID_W] == ~strap_id);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            is_wr_q <= 1'b0;
            ce_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            is_wr_q <= is_wr_d;
            ce_q    <= ~chip_en_n;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        is_wr_d = is_wr_q;
        if (!frame_n) begin
            state_d = (lad_in == NIB_START && ce_q) ? S_TYPE : S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_TYPE: begin
                    cnt_d = '0;
                    if (lad_in[3:1] == TYPE_MEM_RD) begin
                        is_wr_d = 1'b0;
                        state_d = S_ADDR;
                    end else if (lad_in[3:1] == TYPE_MEM_WR) begin
                        is_wr_d = 1'b1;
                        state_d = S_ADDR;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
                S_ADDR: begin
                    if (cnt_q == ADDR_LAST) begin
                        if (!id_ok)       state_d = S_IDLE;
                        else if (is_wr_q) state_d = S_WLO;
                        else              state_d = S_HTAR1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                S_WLO:   state_d = S_WHI;
                S_WHI:   state_d = S_HTAR1;
                S_HTAR1: state_d = S_HTAR2;
                S_HTAR2: state_d = is_wr_q ? S_SYNC : S_RWAIT;
                S_RWAIT: state_d = core_rdy ? S_SYNC : S_RWAIT;
                S_SYNC:  state_d = is_wr_q ? S_TTAR1 : S_RLO;
                S_RLO:   state_d = S_RHI;
                S_RHI:   state_d = S_TTAR1;
                S_TTAR1: state_d = S_TTAR2;
                S_TTAR2: state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        addr_shift  = frame_n && (state_q == S_ADDR);
        wnib_take   = {frame_n && (state_q == S_WHI), frame_n && (state_q == S_WLO)};
        rd_take     = frame_n && (state_q == S_RWAIT) && core_rdy;
        core_rd_req = 1'b0;
        core_wr_req = 1'b0;
        lad_oe      = 1'b0;
        lad_out     = NIB_TAR;
        unique case (state_q)
            S_RWAIT: begin
                lad_oe      = 1'b1;
                lad_out     = NIB_SYNC_WAIT;
                core_rd_req = 1'b1;
            end
            S_SYNC: begin
                lad_oe      = 1'b1;
                lad_out     = NIB_SYNC_OK;
                core_wr_req = is_wr_q;
            end
            S_RLO: begin
                lad_oe  = 1'b1;
                lad_out = rdata_q[NIB_W-1:0];
            end
            S_RHI: begin
                lad_oe  = 1'b1;
                lad_out = rdata_q[2*NIB_W-1:NIB_W];
            end
            S_TTAR1: begin
                lad_oe  = 1'b1;
                lad_out = NIB_TAR;
            end
            default: begin
                lad_oe  = 1'b0;
            end
        endcase
    end

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_req |=> !core_wr_req); // R6
    AST_WR_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_req |-> (lad_oe && lad_out == NIB_SYNC_OK)); // R6
    AST_RD_WITH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd_req |-> (lad_oe && lad_out == NIB_SYNC_WAIT)); // R8
    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd_req && !core_rdy && frame_n) |=> core_rd_req); // R8
    AST_TAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TTAR1) |=> !lad_oe); // R7
    AST_FRAME_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !lad_oe); // R9
    AST_NO_CLAIM_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !ce_q) |=> (state_q == S_IDLE)); // R2

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
    import lpc_tgt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int ID_W   = 4,
    parameter int ID_LSB = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic              chip_en_n,
    input  logic [ID_W-1:0]   strap_id,
    output logic [ADDR_W-1:0] core_addr,
    output logic [DATA_W-1:0] core_wdata,
    output logic              core_wr_req,
    output logic              core_rd_req,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic              core_rdy
);

    localparam int DNIBS = DATA_W / NIB_W;

    logic              addr_shift;
    logic [DNIBS-1:0]  wnib_take;
    logic              rd_take;
    logic [ADDR_W-1:0] addr_nxt;
    logic [DATA_W-1:0] rdata_q;

    lpc_tgt_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ID_W   (ID_W),
        .ID_LSB (ID_LSB)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_n     (frame_n),
        .lad_in      (lad_in),
        .chip_en_n   (chip_en_n),
        .strap_id    (strap_id),
        .addr_nxt    (addr_nxt),
        .rdata_q     (rdata_q),
        .core_rdy    (core_rdy),
        .addr_shift  (addr_shift),
        .wnib_take   (wnib_take),
        .rd_take     (rd_take),
        .lad_out     (lad_out),
        .lad_oe      (lad_oe),
        .core_rd_req (core_rd_req),
        .core_wr_req (core_wr_req)
    );

    lpc_tgt_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .lad_in     (lad_in),
        .addr_shift (addr_shift),
        .wnib_take  (wnib_take),
        .rd_take    (rd_take),
        .core_rdata (core_rdata),
        .addr_q     (core_addr),
        .addr_nxt   (addr_nxt),
        .wdata      (core_wdata),
        .rdata_q    (rdata_q)
    );

endmodule

// File: tb/lpc_mem_target_tb.sv
`timescale 1ns/1ps
module lpc_mem_target_tb;

    localparam int PH = 24;
    localparam int NVEC = 6;
    // fields: wr[48] addr[47:16] data[15:8] strap[7:4] waits[3:0]
    localparam logic [48:0] VEC [0:NVEC-1] = '{
        {1'b1, 32'hFFF0_1234, 8'h3C, 4'h0, 4'h0},
        {1'b0, 32'hFFFF_0010, 8'hA7, 4'h0, 4'h0},
        {1'b0, 32'hFFDA_BCDE, 8'h5E, 4'h2, 4'h3},
        {1'b1, 32'h00C0_0001, 8'hF0, 4'h3, 4'h0},
        {1'b1, 32'hFFF0_2222, 8'h11, 4'h1, 4'h0},
        {1'b0, 32'hFF50_0000, 8'h99, 4'h0, 4'h1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        chip_en_n = 1'b0;
    logic [3:0]  strap_id = 4'h0;
    logic [31:0] core_addr;
    logic [7:0]  core_wdata;
    logic        core_wr_req;
    logic        core_rd_req;
    logic [7:0]  core_rdata = 8'h00;
    logic        core_rdy = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int n_oe, n_wr, n_rd;
    logic [31:0] got_wa, got_ra;
    logic [7:0]  got_wd;
    logic        ph_oe  [PH];
    logic [3:0]  ph_lad [PH];

    always #2 clk = ~clk;

    lpc_mem_target u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .chip_en_n(chip_en_n),
        .strap_id(strap_id), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_wr_req(core_wr_req), .core_rd_req(core_rd_req),
        .core_rdata(core_rdata), .core_rdy(core_rdy)
    );

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one bus clock at the falling edge, then sample the state-driven outputs.
    task automatic step(input logic f, input logic [3:0] l, input logic r, input logic ce);
        @(negedge clk);
        frame_n = f;
        lad_in = l;
        core_rdy = r;
        chip_en_n = ce;
        #1;
        if (lad_oe) n_oe++;
        if (core_rd_req) begin n_rd++; got_ra = core_addr; end
        if (core_wr_req) begin n_wr++; got_wa = core_addr; got_wd = core_wdata; end
    endtask

    task automatic run_cycle(input logic wr, input logic [3:0] typ, input logic [31:0] a,
                             input logic [7:0] d, input int waits);
        n_oe = 0; n_wr = 0; n_rd = 0;
        got_wa = '0; got_ra = '0; got_wd = '0;
        core_rdata = d;
        step(1'b0, 4'h0, 1'b0, 1'b0);
        step(1'b1, typ, 1'b0, 1'b0);
        for (int i = 7; i >= 0; i--) step(1'b1, a[4*i +: 4], 1'b0, 1'b0);
        if (wr) begin
            step(1'b1, d[3:0], 1'b0, 1'b0);
            step(1'b1, d[7:4], 1'b0, 1'b0);
        end
        step(1'b1, 4'hF, 1'b0, 1'b0);
        step(1'b1, 4'hF, 1'b0, 1'b0);
        for (int k = 0; k < PH; k++) begin
            step(1'b1, 4'hF, (k >= waits), 1'b0);
            ph_oe[k] = lad_oe;
            ph_lad[k] = lad_out;
        end
        core_rdy = 1'b0;
    endtask

    task automatic verify(input logic wr, input logic [31:0] a, input logic [7:0] d,
                          input int waits, input logic claim);
        int bad;
        if (!claim) begin
            check("R5", "unclaimed oe clocks", n_oe, 0);
            check("R5", "unclaimed requests", n_wr + n_rd, 0);
        end else if (wr) begin
            check("R6", "write pulses", n_wr, 1);
            check("R4", "write address", got_wa, a);
            check("R6", "write data", got_wd, d);
            check("R7", "sync clock", {ph_oe[0], ph_lad[0]}, 5'h10);
            check("R7", "turnaround clock", {ph_oe[1], ph_lad[1]}, 5'h1F);
            check("R7", "released after tar", ph_oe[2], 0);
            check("R7", "oe clock count", n_oe, 2);
        end else begin
            bad = 0;
            for (int k = 0; k <= waits; k++) if ({ph_oe[k], ph_lad[k]} != 5'h16) bad++;
            check("R8", "wait sync clocks wrong", bad, 0);
            check("R8", "read request clocks", n_rd, waits + 1);
            check("R4", "read address", got_ra, a);
            check("R8", "ready sync", {ph_oe[waits+1], ph_lad[waits+1]}, 5'h10);
            check("R8", "read byte", {ph_lad[waits+3], ph_lad[waits+2]}, d);
            check("R7", "read turnaround", {ph_oe[waits+4], ph_lad[waits+4]}, 5'h1F);
            check("R7", "read release", ph_oe[waits+5], 0);
            check("R7", "read oe count", n_oe, waits + 5);
            check("R8", "no write on read", n_wr, 0);
        end
    endtask

    initial begin
        // R1: reset state, even with a start nibble on the bus
        step(1'b1, 4'hF, 1'b0, 1'b0);
        step(1'b0, 4'h0, 1'b0, 1'b0);
        check("R1", "oe in reset", lad_oe, 0);
        check("R1", "requests in reset", {core_rd_req, core_wr_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 4'hF, 1'b0, 1'b0);
        step(1'b1, 4'hF, 1'b0, 1'b0);
        check("R1", "oe after reset", lad_oe, 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            logic        vwr;
            logic [31:0] va;
            logic [7:0]  vd;
            logic [3:0]  vs;
            int          vw;
            vwr = VEC[v][48];
            va  = VEC[v][47:16];
            vd  = VEC[v][15:8];
            vs  = VEC[v][7:4];
            vw  = int'(VEC[v][3:0]);
            strap_id = vs;
            run_cycle(vwr, vwr ? 4'b0110 : 4'b0100, va, vd, vw);
            verify(vwr, va, vd, vw, va[23:20] == ~vs);
        end

        // R2: chip enable not low on the clock before start
        strap_id = 4'h0;
        step(1'b1, 4'hF, 1'b0, 1'b1);
        step(1'b1, 4'hF, 1'b0, 1'b1);
        run_cycle(1'b1, 4'b0110, 32'hFFF0_0044, 8'h66, 0);
        check("R2", "late chip enable oe", n_oe, 0);
        check("R2", "late chip enable write", n_wr, 0);

        // R3: non-memory cycle type is ignored
        step(1'b1, 4'hF, 1'b0, 1'b0);
        run_cycle(1'b0, 4'b0000, 32'hFFF0_0050, 8'h12, 0);
        check("R3", "bad type oe", n_oe, 0);
        check("R3", "bad type requests", n_rd + n_wr, 0);

        // R3: low type bit is don't-care
        run_cycle(1'b0, 4'b0101, 32'hFFF0_0060, 8'hC3, 1);
        verify(1'b0, 32'hFFF0_0060, 8'hC3, 1, 1'b1);
        run_cycle(1'b1, 4'b0111, 32'hFFF1_0061, 8'h4D, 0);
        check("R3", "write type 0111 address", got_wa, 32'hFFF1_0061);

        // R9: abort partway through an address, then restart
        step(1'b0, 4'h0, 1'b0, 1'b0);
        step(1'b1, 4'b0110, 1'b0, 1'b0);
        step(1'b1, 4'h1, 1'b0, 1'b0);
        step(1'b1, 4'h2, 1'b0, 1'b0);
        step(1'b1, 4'h3, 1'b0, 1'b0);
        run_cycle(1'b1, 4'b0110, 32'hAAF5_5AA5, 8'h81, 0);
        check("R9", "restart write count", n_wr, 1);
        check("R9", "restart address", got_wa, 32'hAAF5_5AA5);
        check("R9", "restart data", got_wd, 8'h81);

        // R9: frame low during the read wait releases the bus
        n_oe = 0;
        core_rdata = 8'h00;
        step(1'b0, 4'h0, 1'b0, 1'b0);
        step(1'b1, 4'b0100, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b1, 4'hF, 1'b0, 1'b0);
        step(1'b1, 4'hF, 1'b0, 1'b0);
        step(1'b1, 4'hF, 1'b0, 1'b0);
        step(1'b1, 4'hF, 1'b0, 1'b0);
        check("R8", "wait sync before abort", {lad_oe, lad_out}, 5'h16);
        step(1'b0, 4'hF, 1'b0, 1'b0);
        step(1'b1, 4'hF, 1'b0, 1'b0);
        check("R9", "oe after abort", lad_oe, 0);
        check("R9", "read request after abort", core_rd_req, 0);

        finish_up();
    end

endmodule